// File: doc/BRIEF.md
# Store Set Dependence Predictor

This block decides, for a load that is ready to issue, whether it has to wait for an older store. It learns from ordering violations. When the pipeline finds that a load read memory before an older store to the same address had written it, the pair (load PC, store PC) is sent to the training port. The block records that store PC in a small set that belongs to the load PC. A load PC that has never been trained has an empty set, so it issues as soon as it is ready.

On each refresh of the load/store queue, the scheduler presents one ready load and the PCs of the older stores that are still unready, one lane per store with a lane-valid bit. The block raises the hold output in the same cycle if one of those store PCs is in the load's learned set. When the store leaves the queue, the scheduler stops presenting it and the load is released. The table is direct-mapped on the low load-PC bits and holds a full-PC tag. Each entry has a bounded number of store slots, replaced oldest first. Recovery from the violation flush is handled outside this block.

Top module: `ssp_predictor`

## Requirements
- R1: A synchronous active-high reset empties every table entry. After reset no query holds a load until training has taken place.
- R2: A load PC that has never been trained is never held back, whatever store PCs are presented with it.
- R3: A training request is written on the clock edge that samples it. A query in the same cycle sees the table as it was before that edge, and the new store PC takes effect from the next cycle.
- R4: `q_stall` is 1 in the same cycle when `q_valid` is 1, the load's entry holds a matching tag, and a lane with its valid bit set carries a store PC that is in the load's set.
- R5: When none of the valid lanes carries a store PC from the load's set, `q_stall` is 0. This is the case once the blocking store has left the queue and its lane is no longer valid.
- R6: A lane whose bit in `q_store_vld` is 0 is ignored, even if its PC matches a member of the set. Lane j occupies bits [j*PC_W +: PC_W] of `q_store_pc`.
- R7: The entry index is the low log2(ENTRIES) bits of the load PC, and a hit needs the whole load PC to equal the stored tag. Training a different load PC with the same index replaces the entry with a set that holds only the new store PC. The evicted load then no longer stalls.
- R8: Each set holds up to WAYS store PCs. When a full set learns a new store PC, the new PC overwrites the store PC that was added earliest.
- R9: Training a store PC that is already in the load's set leaves the set unchanged and does not advance the replacement order.
- R10: One store PC can be a member of the sets of several load PCs at once. Each of those loads stalls on it independently.
- R11: While `q_valid` is 0, `q_stall` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trn_valid | input | 1 | A violation was detected; learn the pair below |
| trn_load_pc | input | PC_W | PC of the offending load |
| trn_store_pc | input | PC_W | PC of the store it overtook |
| q_valid | input | 1 | A ready load is being considered this cycle |
| q_load_pc | input | PC_W | PC of the ready load |
| q_store_pc | input | LANES*PC_W | PCs of older unready stores, lane j at [j*PC_W +: PC_W] |
| q_store_vld | input | LANES | Lane j carries a real older unready store |
| q_stall | output | 1 | Hold the load this cycle |

## Verification
The assertions take for granted that the training and query inputs carry known values whenever their valid bits are set. They also assume that at most one violation pair is presented per cycle, which the single training port enforces. The next-cycle training check further relies on lane 0 carrying a defined PC when it is marked valid. The stimulus changes inputs only on falling edges and drives defined PCs on all lanes, including invalid ones. Training is sent as one pair per cycle. Random traffic draws its load PCs from a small pool that aliases onto the same indexes, so replacement and tag misses occur constantly without breaking these assumptions.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    // Default geometry of the predictor
    localparam int unsigned DEF_PC_W    = 16;
    localparam int unsigned DEF_ENTRIES = 16;
    localparam int unsigned DEF_WAYS    = 4;
    localparam int unsigned DEF_LANES   = 4;

    // Kind of update an entry performs on a clock edge
    typedef enum logic [1:0] {
        UPD_IDLE   = 2'd0,
        UPD_ALLOC  = 2'd1,
        UPD_APPEND = 2'd2,
        UPD_KEEP   = 2'd3
    } upd_kind_e;

    // Pick the update kind from the training request and entry state
    function automatic upd_kind_e pick_update(logic wr, logic tag_hit, logic present);
        if (!wr)          return UPD_IDLE;
        else if (!tag_hit) return UPD_ALLOC;
        else if (present)  return UPD_KEEP;
        else               return UPD_APPEND;
    endfunction

endpackage

// File: rtl/ssp_entry.sv
module ssp_entry
    import ssp_pkg::*;
#(
    parameter int unsigned PC_W = DEF_PC_W,
    parameter int unsigned WAYS = DEF_WAYS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [PC_W-1:0]      wr_load_pc,
    input  logic [PC_W-1:0]      wr_store_pc,
    output logic                 ent_valid,
    output logic [PC_W-1:0]      ent_tag,
    output logic [WAYS-1:0]      slot_vld,
    output logic [WAYS*PC_W-1:0] slot_pc
);

    localparam int unsigned PTR_W = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam logic [PTR_W-1:0] PTR_LAST  = PTR_W'(WAYS - 1);
    localparam logic [PTR_W-1:0] PTR_AFTER = PTR_W'((WAYS > 1) ? 1 : 0);

    logic [PC_W-1:0]  slots [WAYS];
    logic [PTR_W-1:0] oldest;
    logic [PTR_W-1:0] oldest_nxt;
    logic             tag_hit;
    logic             present;
    logic             pair_dup;
    upd_kind_e        kind;

    genvar gw;
    generate
        for (gw = 0; gw < WAYS; gw++) begin : g_out
            assign slot_pc[gw*PC_W +: PC_W] = slots[gw];
        end
    endgenerate

    always_comb begin
        tag_hit = ent_valid && (ent_tag == wr_load_pc);
        present = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (slot_vld[w] && (slots[w] == wr_store_pc)) present = 1'b1;
        end
        kind       = pick_update(wr_en, tag_hit, present);
        oldest_nxt = (oldest == PTR_LAST) ? '0 : oldest + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_valid <= 1'b0;
            slot_vld  <= '0;
            oldest    <= '0;
        end else begin
            case (kind)
                UPD_ALLOC: begin
                    ent_valid <= 1'b1;
                    ent_tag   <= wr_load_pc;
                    slot_vld  <= WAYS'(1);
                    slots[0]  <= wr_store_pc;
                    oldest    <= PTR_AFTER;
                end
                UPD_APPEND: begin
                    slots[oldest]    <= wr_store_pc;
                    slot_vld[oldest] <= 1'b1;
                    oldest           <= oldest_nxt;
                end
                default: begin
                end
            endcase
        end
    end

    // Checker logic: any two valid slots holding the same PC
    always_comb begin
        pair_dup = 1'b0;
        for (int a = 0; a < WAYS; a++) begin
            for (int b = a + 1; b < WAYS; b++) begin
                if (slot_vld[a] && slot_vld[b] && (slots[a] == slots[b])) pair_dup = 1'b1;
            end
        end
    end

    AST_RESET_EMPTIES: assert property (@(posedge clk) rst |=> !ent_valid && (slot_vld == '0)); // R1
    AST_APPEND_LANDS: assert property (@(posedge clk) disable iff (rst)
        (kind == UPD_APPEND) |=> (slots[$past(oldest)] == $past(wr_store_pc)) && ent_valid); // R3
    AST_ALLOC_FRESH: assert property (@(posedge clk) disable iff (rst)
        (kind == UPD_ALLOC) |=> ent_valid && (ent_tag == $past(wr_load_pc)) && ($countones(slot_vld) == 1)); // R7
    AST_KEEP_STABLE: assert property (@(posedge clk) disable iff (rst)
        (kind == UPD_KEEP) |=> $stable(slot_vld) && $stable(slot_pc) && $stable(ent_tag)); // R9
    AST_NO_DUP_SLOT: assert property (@(posedge clk) disable iff (rst) !pair_dup); // R9

endmodule

// File: rtl/ssp_match.sv
module ssp_match
    import ssp_pkg::*;
#(
    parameter int unsigned PC_W  = DEF_PC_W,
    parameter int unsigned WAYS  = DEF_WAYS,
    parameter int unsigned LANES = DEF_LANES
) (
    input  logic [WAYS-1:0]       set_vld,
    input  logic [WAYS*PC_W-1:0]  set_pc,
    input  logic [LANES-1:0]      lane_vld,
    input  logic [LANES*PC_W-1:0] lane_pc,
    output logic                  any_hit
);

    logic [LANES-1:0] lane_hit;

    genvar gl;
    generate
        for (gl = 0; gl < LANES; gl++) begin : g_lane
            logic [WAYS-1:0] way_eq;
            for (genvar gw = 0; gw < WAYS; gw++) begin : g_way
                assign way_eq[gw] = set_vld[gw] && (set_pc[gw*PC_W +: PC_W] == lane_pc[gl*PC_W +: PC_W]);
            end
            assign lane_hit[gl] = lane_vld[gl] && (|way_eq);
        end
    endgenerate

    assign any_hit = |lane_hit;

endmodule

// File: rtl/ssp_predictor.sv
module ssp_predictor
    import ssp_pkg::*;
#(
    parameter int unsigned PC_W    = DEF_PC_W,
    parameter int unsigned ENTRIES = DEF_ENTRIES,
    parameter int unsigned WAYS    = DEF_WAYS,
    parameter int unsigned LANES   = DEF_LANES
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  trn_valid,
    input  logic [PC_W-1:0]       trn_load_pc,
    input  logic [PC_W-1:0]       trn_store_pc,
    input  logic                  q_valid,
    input  logic [PC_W-1:0]       q_load_pc,
    input  logic [LANES*PC_W-1:0] q_store_pc,
    input  logic [LANES-1:0]      q_store_vld,
    output logic                  q_stall
);

    localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [IDX_W-1:0]      trn_idx;
    logic [IDX_W-1:0]      q_idx;
    logic                  e_valid [ENTRIES];
    logic [PC_W-1:0]       e_tag   [ENTRIES];
    logic [WAYS-1:0]       e_svld  [ENTRIES];
    logic [WAYS*PC_W-1:0]  e_spc   [ENTRIES];
    logic                  sel_hit;
    logic [WAYS-1:0]       sel_svld;
    logic [WAYS*PC_W-1:0]  sel_spc;
    logic                  set_hit;

    assign trn_idx = trn_load_pc[IDX_W-1:0];
    assign q_idx   = q_load_pc[IDX_W-1:0];

    genvar ge;
    generate
        for (ge = 0; ge < ENTRIES; ge++) begin : g_ent
            ssp_entry #(.PC_W(PC_W), .WAYS(WAYS)) u_ent (
                .clk         (clk),
                .rst         (rst),
                .wr_en       (trn_valid && (trn_idx == IDX_W'(ge))),
                .wr_load_pc  (trn_load_pc),
                .wr_store_pc (trn_store_pc),
                .ent_valid   (e_valid[ge]),
                .ent_tag     (e_tag[ge]),
                .slot_vld    (e_svld[ge]),
                .slot_pc     (e_spc[ge])
            );
        end
    endgenerate

    always_comb begin
        sel_hit  = q_valid && e_valid[q_idx] && (e_tag[q_idx] == q_load_pc);
        sel_svld = sel_hit ? e_svld[q_idx] : '0;
        sel_spc  = e_spc[q_idx];
    end

    ssp_match #(.PC_W(PC_W), .WAYS(WAYS), .LANES(LANES)) u_match (
        .set_vld  (sel_svld),
        .set_pc   (sel_spc),
        .lane_vld (q_store_vld),
        .lane_pc  (q_store_pc),
        .any_hit  (set_hit)
    );

    assign q_stall = sel_hit && set_hit;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) !q_valid |-> !q_stall); // R11
    AST_NO_LANE_NO_HOLD: assert property (@(posedge clk) disable iff (rst)
        (q_store_vld == '0) |-> !q_stall); // R6
    AST_FRESH_AFTER_RESET: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> !q_stall); // R1
    AST_TRAINED_HOLDS: assert property (@(posedge clk) disable iff (rst)
        ($past(trn_valid) && !$past(rst) && q_valid && (q_load_pc == $past(trn_load_pc)) &&
         q_store_vld[0] && (q_store_pc[PC_W-1:0] == $past(trn_store_pc))) |-> q_stall); // R3

endmodule

// File: tb/sim_ssp_predictor.sv
module sim_ssp_predictor;

    localparam int PC_W  = 16;
    localparam int ENT   = 16;
    localparam int WAYS  = 4;
    localparam int LANES = 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic                  rst;
    logic                  trn_valid;
    logic [PC_W-1:0]       trn_load_pc, trn_store_pc;
    logic                  q_valid;
    logic [PC_W-1:0]       q_load_pc;
    logic [LANES*PC_W-1:0] q_store_pc;
    logic [LANES-1:0]      q_store_vld;
    logic                  q_stall;

    ssp_predictor #(.PC_W(PC_W), .ENTRIES(ENT), .WAYS(WAYS), .LANES(LANES)) u0 (
        .clk(clk), .rst(rst), .trn_valid(trn_valid), .trn_load_pc(trn_load_pc),
        .trn_store_pc(trn_store_pc), .q_valid(q_valid), .q_load_pc(q_load_pc),
        .q_store_pc(q_store_pc), .q_store_vld(q_store_vld), .q_stall(q_stall)
    );

    // Expected table, built from the requirements
    logic            mval [ENT];
    logic [PC_W-1:0] mtag [ENT];
    logic [PC_W-1:0] mset [ENT][WAYS];
    logic [WAYS-1:0] mslv [ENT];
    int              mold [ENT];

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    function automatic logic [PC_W-1:0] spc(int k);
        return PC_W'(16'h8000 + 4 * k);
    endfunction

    function automatic logic [PC_W-1:0] lpc(int variant, int idx);
        return PC_W'(16'h0100 * (variant + 1) + idx);
    endfunction

    task automatic model_clear();
        for (int i = 0; i < ENT; i++) begin
            mval[i] = 1'b0; mslv[i] = '0; mold[i] = 0; mtag[i] = '0;
            for (int w = 0; w < WAYS; w++) mset[i][w] = '0;
        end
    endtask

    task automatic model_train(logic [PC_W-1:0] l, logic [PC_W-1:0] s);
        int  idx = int'(l[3:0]);
        bit  has = 0;
        if (mval[idx] && mtag[idx] == l) begin
            for (int w = 0; w < WAYS; w++) if (mslv[idx][w] && mset[idx][w] == s) has = 1;
            if (!has) begin
                mset[idx][mold[idx]] = s;
                mslv[idx][mold[idx]] = 1'b1;
                mold[idx] = (mold[idx] + 1) % WAYS;
            end
        end else begin
            mval[idx] = 1'b1; mtag[idx] = l; mslv[idx] = 4'b0001;
            mset[idx][0] = s; mold[idx] = 1;
        end
    endtask

    function automatic logic model_stall();
        int idx = int'(q_load_pc[3:0]);
        if (!q_valid || !mval[idx] || mtag[idx] != q_load_pc) return 1'b0;
        for (int j = 0; j < LANES; j++)
            if (q_store_vld[j])
                for (int w = 0; w < WAYS; w++)
                    if (mslv[idx][w] && mset[idx][w] == q_store_pc[j*PC_W +: PC_W]) return 1'b1;
        return 1'b0;
    endfunction

    task automatic check(string req);
        logic exp = model_stall();
        n_chk++;
        if (q_stall !== exp) begin
            n_bad++;
            $display("FAIL %s: q_stall=%0b expected %0b (load %h lanes %h vld %b)",
                     req, q_stall, exp, q_load_pc, q_store_pc, q_store_vld);
        end
    endtask

    // Called at a falling edge; trains one pair across the next rising edge
    task automatic train(logic [PC_W-1:0] l, logic [PC_W-1:0] s);
        trn_valid = 1'b1; trn_load_pc = l; trn_store_pc = s;
        @(posedge clk);
        model_train(l, s);
        @(negedge clk);
        trn_valid = 1'b0;
    endtask

    // Single-lane query with the store in lane `ln`, other lanes hold non-member PCs
    task automatic query1(logic [PC_W-1:0] l, logic [PC_W-1:0] s, int ln, logic v, string req);
        q_valid = 1'b1; q_load_pc = l;
        for (int j = 0; j < LANES; j++) q_store_pc[j*PC_W +: PC_W] = PC_W'(16'hF000 + j);
        q_store_pc[ln*PC_W +: PC_W] = s;
        q_store_vld = '0;
        q_store_vld[ln] = v;
        #1 check(req);
    endtask

    initial begin
        rst = 1'b1; trn_valid = 1'b0; trn_load_pc = '0; trn_store_pc = '0;
        q_valid = 1'b0; q_load_pc = '0; q_store_pc = '0; q_store_vld = '0;
        model_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 / R2: nothing trained, every load goes
        for (int i = 0; i < ENT; i++) begin
            q_valid = 1'b1; q_load_pc = lpc(0, i); q_store_vld = '1;
            for (int j = 0; j < LANES; j++) q_store_pc[j*PC_W +: PC_W] = spc(j);
            #1 check("R1");
            query1(lpc(1, i), spc(i % 6), i % LANES, 1'b1, "R2");
        end

        // Fill every entry: S0..S3, duplicate S1, then S4, S5 overflow
        for (int i = 0; i < ENT; i++) begin
            @(negedge clk);
            for (int k = 0; k < 4; k++) train(lpc(0, i), spc(k));
            train(lpc(0, i), spc(1));
            train(lpc(0, i), spc(4));
            train(lpc(0, i), spc(5));
        end
        for (int i = 0; i < ENT; i++) begin
            query1(lpc(0, i), spc(0), 0, 1'b1, "R8");
            query1(lpc(0, i), spc(1), 1, 1'b1, "R8");
            query1(lpc(0, i), spc(2), i % LANES, 1'b1, "R9");
            query1(lpc(0, i), spc(3), 3, 1'b1, "R4");
            query1(lpc(0, i), spc(4), 2, 1'b1, "R4");
            query1(lpc(0, i), spc(5), 1, 1'b1, "R10");
            query1(lpc(0, i), spc(3), 3, 1'b0, "R6");
            query1(lpc(0, i), spc(7), 0, 1'b1, "R5");
            q_valid = 1'b0; q_store_vld = '1;
            #1 check("R11");
        end

        // R7: alias onto index 3 evicts the old load
        @(negedge clk);
        train(lpc(1, 3), spc(2));
        query1(lpc(0, 3), spc(2), 0, 1'b1, "R7");
        query1(lpc(1, 3), spc(2), 0, 1'b1, "R7");
        query1(lpc(1, 3), spc(4), 0, 1'b1, "R7");

        // R3: training and query in the same cycle
        @(negedge clk);
        trn_valid = 1'b1; trn_load_pc = lpc(2, 5); trn_store_pc = spc(7);
        query1(lpc(2, 5), spc(7), 2, 1'b1, "R3");
        @(posedge clk);
        model_train(lpc(2, 5), spc(7));
        @(negedge clk);
        trn_valid = 1'b0;
        #1 check("R3");

        // Random sweep over aliasing load PCs and a small store pool
        for (int it = 0; it < 4000; it++) begin
            logic [31:0] r = $urandom;
            @(negedge clk);
            trn_valid    = r[0];
            trn_load_pc  = {6'd0, r[2:1], 4'd0, r[6:3]};
            trn_store_pc = spc(int'(r[9:7]));
            q_valid      = r[10] | r[11];
            q_load_pc    = {6'd0, r[13:12], 4'd0, r[17:14]};
            for (int j = 0; j < LANES; j++) q_store_pc[j*PC_W +: PC_W] = spc(int'(r[18+3*j +: 3]));
            q_store_vld  = r[31:28];
            #1 check("R4");
            @(posedge clk);
            if (trn_valid) model_train(trn_load_pc, trn_store_pc);
        end

        @(negedge clk);
        trn_valid = 1'b0; q_valid = 1'b0;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule